// File: doc/BRIEF.md
# Cache Line Flush Controller

This controller carries out a flush of one physical line against a small local set-associative cache whose lines carry a five-state coherence tag (Modified, Owned, Exclusive, Shared, Invalid), and against one local write-combining buffer. A flush request names a line address. The controller looks the line up through a combinational tag/state read port. A dirty copy (Modified or Owned) is written back to a memory write port in ascending beats. The line's state is then set to Invalid. Clean copies are dropped without any write.

Independently of the cache, the controller compares the write-combining buffer's line address with the flushed line. On a match it writes the buffer's full contents to memory and pulses a clear signal back to the buffer, even when the line is not cached. When both writes are needed, the buffer drain goes first, so the cached copy, which is the newer data, reaches memory last. Only this single local buffer is examined.

The request side is a valid/ready handshake with a one-cycle completion pulse. While a flush is in progress, ready stays low and further requests wait.

Top module: `lflush_ctrl`

## Requirements
- R1: A line whose way state is Modified (encoding 3'd4) is written to memory as LINE_BYTES*8/DATA_W beats. Beat b goes to byte address line*LINE_BYTES + b*DATA_W/8 and carries bits [b*DATA_W +: DATA_W] of the line. The way state is written to Invalid only together with acceptance of the last beat.
- R2: A line whose way state is Owned (encoding 3'd3) is written back and invalidated exactly as in R1.
- R3: A line in Exclusive (3'd2) or Shared (3'd1) is set to Invalid with no memory write. The done output is high in the second cycle after the cycle in which the request is accepted.
- R4: A line not present in the cache, with no matching buffer, causes no memory write and no tag write, and completes with the same timing as R3.
- R5: When wcb_valid is high and wcb_line equals the flushed line, every beat of wcb_data is written to that line's addresses in the R1 order. wcb_clear pulses for one cycle with the last accepted beat. This also happens when the line misses in the cache.
- R6: When the buffer matches and the cached line is dirty, all buffer beats are issued before any cache writeback beat.
- R7: A buffer whose line address differs from the flushed line is neither written nor cleared.
- R8: A beat offered while mem_wready is low is held with an unchanged address. done is a single-cycle pulse, high in the cycle after the last beat is accepted.
- R9: req_ready is low from the cycle after acceptance until done. A request held during that time is not serviced, and the state of the line it names is unchanged.
- R10: A way whose state is Invalid (3'd0) never hits, even when its tag matches. Every tag write carries state 3'd0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Flush request present |
| req_line | input | ADDR_W-$clog2(LINE_BYTES) | Line address to flush |
| req_ready | output | 1 | Controller idle, request can be accepted |
| done | output | 1 | One-cycle completion pulse |
| tag_set | output | $clog2(SETS) | Set index for the tag/state read and write, and for the line data read |
| tag_rd_tags | input | WAYS*TAG_W | Tags of all ways of tag_set, way 0 in the low bits |
| tag_rd_states | input | WAYS*3 | Coherence state of every way of tag_set |
| tag_wr_en | output | 1 | Write the state of one way |
| tag_wr_way | output | max(1,$clog2(WAYS)) | Way to write |
| tag_wr_state | output | 3 | State written (always Invalid) |
| dat_way | output | max(1,$clog2(WAYS)) | Way whose line data is read |
| dat_line | input | LINE_BYTES*8 | Line data of tag_set/dat_way |
| wcb_valid | input | 1 | Write-combining buffer holds data |
| wcb_line | input | ADDR_W-$clog2(LINE_BYTES) | Line address targeted by the buffer |
| wcb_data | input | LINE_BYTES*8 | Buffer contents |
| wcb_clear | output | 1 | Buffer drained, release it |
| mem_wvalid | output | 1 | Memory write beat valid |
| mem_wready | input | 1 | Memory accepts the beat |
| mem_waddr | output | ADDR_W | Byte address of the beat |
| mem_wdata | output | DATA_W | Beat data |

## Verification
A wrong lookup outcome shows up within two cycles of acceptance: a write burst starts when none should, or no burst starts when one should, or done arrives early. A corrupted beat counter shows up on the first affected beat as a wrong address or data slice. It can also show up as a burst of the wrong length, seen when done arrives. A lost or early invalidation is visible when the bench reads back the way state after done. Ordering faults between drain and writeback appear as buffer data following line data in the memory log.

// File: rtl/lflush_pkg.sv
package lflush_pkg;

   typedef enum logic [2:0] {
      LS_INV = 3'd0,
      LS_SHR = 3'd1,
      LS_EXC = 3'd2,
      LS_OWN = 3'd3,
      LS_MOD = 3'd4
   } line_st_e;

   typedef enum logic [1:0] {
      F_IDLE  = 2'd0,
      F_LOOK  = 2'd1,
      F_DRAIN = 2'd2,
      F_WBACK = 2'd3
   } flush_st_e;

endpackage

// File: rtl/lflush_way_match.sv
module lflush_way_match
   import lflush_pkg::*;
#(
   parameter int WAYS  = 4,
   parameter int TAG_W = 22,
   parameter int WAY_W = 2
) (
   input  logic [TAG_W-1:0]      look_tag,
   input  logic [WAYS*TAG_W-1:0] way_tags,
   input  logic [WAYS*3-1:0]     way_states,
   output logic                  hit,
   output logic [WAY_W-1:0]      hit_way,
   output logic                  hit_dirty
);

   logic [WAYS-1:0] match_v;
   logic [WAYS-1:0] dirty_v;

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic [2:0] st;
      assign st         = way_states[w*3 +: 3];
      assign match_v[w] = (way_tags[w*TAG_W +: TAG_W] == look_tag) && (st != LS_INV);
      assign dirty_v[w] = match_v[w] && ((st == LS_MOD) || (st == LS_OWN));
   end

   always_comb begin
      hit       = |match_v;
      hit_dirty = |dirty_v;
      hit_way   = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (match_v[w]) hit_way = WAY_W'(w);
      end
   end

endmodule

// File: rtl/lflush_wcb_match.sv
module lflush_wcb_match #(
   parameter int LADDR_W = 26
) (
   input  logic               wcb_valid,
   input  logic [LADDR_W-1:0] wcb_line,
   input  logic [LADDR_W-1:0] look_line,
   output logic               match
);

   assign match = wcb_valid && (wcb_line == look_line);

endmodule

// File: rtl/lflush_beat_seq.sv
module lflush_beat_seq #(
   parameter int BEATS  = 4,
   parameter int BEAT_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              adv,
   output logic [BEAT_W-1:0] beat,
   output logic              last
);

   if (BEATS == 1) begin : g_single
      logic unused_seq;
      assign unused_seq = clk ^ rst_n ^ clr ^ adv;
      assign beat = '0;
      assign last = 1'b1;
   end else begin : g_multi
      logic [BEAT_W-1:0] cnt_q;
      assign beat = cnt_q;
      assign last = (cnt_q == BEAT_W'(BEATS-1));
      always_ff @(posedge clk) begin
         if (!rst_n)   cnt_q <= '0;
         else if (clr) cnt_q <= '0;
         else if (adv) cnt_q <= last ? '0 : cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/lflush_ctrl.sv
module lflush_ctrl
   import lflush_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 64,
   parameter int SETS       = 16,
   parameter int WAYS       = 4,
   parameter int DATA_W     = 128,
   localparam int OFF_W     = $clog2(LINE_BYTES),
   localparam int SET_W     = $clog2(SETS),
   localparam int LADDR_W   = ADDR_W - OFF_W,
   localparam int TAG_W     = LADDR_W - SET_W,
   localparam int LINE_W    = LINE_BYTES * 8,
   localparam int WAY_W     = (WAYS > 1) ? $clog2(WAYS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   input  logic [LADDR_W-1:0]   req_line,
   output logic                 req_ready,
   output logic                 done,
   output logic [SET_W-1:0]     tag_set,
   input  logic [WAYS*TAG_W-1:0] tag_rd_tags,
   input  logic [WAYS*3-1:0]    tag_rd_states,
   output logic                 tag_wr_en,
   output logic [WAY_W-1:0]     tag_wr_way,
   output logic [2:0]           tag_wr_state,
   output logic [WAY_W-1:0]     dat_way,
   input  logic [LINE_W-1:0]    dat_line,
   input  logic                 wcb_valid,
   input  logic [LADDR_W-1:0]   wcb_line,
   input  logic [LINE_W-1:0]    wcb_data,
   output logic                 wcb_clear,
   output logic                 mem_wvalid,
   input  logic                 mem_wready,
   output logic [ADDR_W-1:0]    mem_waddr,
   output logic [DATA_W-1:0]    mem_wdata
);

   localparam int BEATS  = LINE_W / DATA_W;
   localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
   localparam int BOFF_W = $clog2(DATA_W / 8);

   if ((1 << OFF_W) != LINE_BYTES) begin : g_err_line
      $error("LINE_BYTES must be a power of two");
   end
   if (BEATS * DATA_W != LINE_W) begin : g_err_beat
      $error("DATA_W must divide the line width");
   end
   if ((1 << SET_W) != SETS || TAG_W < 1) begin : g_err_set
      $error("SETS must be a power of two leaving tag bits");
   end

   flush_st_e          st_q;
   logic [LADDR_W-1:0] line_q;
   logic [WAY_W-1:0]   way_q;
   logic               dirty_q;
   logic               done_q;

   logic               hit, hit_dirty, wcb_hit;
   logic [WAY_W-1:0]   hit_way;
   logic [BEAT_W-1:0]  beat;
   logic               beat_last, beat_adv;
   logic [LINE_W-1:0]  src_line;

   assign tag_set = line_q[SET_W-1:0];

   lflush_way_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_match (
      .look_tag   (line_q[LADDR_W-1:SET_W]),
      .way_tags   (tag_rd_tags),
      .way_states (tag_rd_states),
      .hit        (hit),
      .hit_way    (hit_way),
      .hit_dirty  (hit_dirty)
   );

   lflush_wcb_match #(.LADDR_W(LADDR_W)) u_wcb (
      .wcb_valid (wcb_valid),
      .wcb_line  (wcb_line),
      .look_line (line_q),
      .match     (wcb_hit)
   );

   lflush_beat_seq #(.BEATS(BEATS), .BEAT_W(BEAT_W)) u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (st_q == F_LOOK),
      .adv   (beat_adv),
      .beat  (beat),
      .last  (beat_last)
   );

   // Memory beat path: buffer drain first, then cached line
   assign mem_wvalid = (st_q == F_DRAIN) || (st_q == F_WBACK);
   assign beat_adv   = mem_wvalid && mem_wready;
   assign src_line   = (st_q == F_DRAIN) ? wcb_data : dat_line;
   assign mem_wdata  = src_line[int'(beat)*DATA_W +: DATA_W];
   assign mem_waddr  = {line_q, {OFF_W{1'b0}}} | (ADDR_W'(beat) << BOFF_W);
   assign dat_way    = way_q;

   // Clean hits drop at lookup, dirty ones with the final writeback beat
   assign tag_wr_en    = ((st_q == F_LOOK) && hit && !hit_dirty) ||
                         ((st_q == F_WBACK) && beat_adv && beat_last);
   assign tag_wr_way   = (st_q == F_LOOK) ? hit_way : way_q;
   assign tag_wr_state = LS_INV;

   assign wcb_clear = (st_q == F_DRAIN) && beat_adv && beat_last;
   assign req_ready = (st_q == F_IDLE);
   assign done      = done_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= F_IDLE;
         line_q  <= '0;
         way_q   <= '0;
         dirty_q <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (st_q)
            F_IDLE: begin
               if (req_valid) begin
                  line_q <= req_line;
                  st_q   <= F_LOOK;
               end
            end
            F_LOOK: begin
               way_q   <= hit_way;
               dirty_q <= hit_dirty;
               if (wcb_hit) begin
                  st_q <= F_DRAIN;
               end else if (hit_dirty) begin
                  st_q <= F_WBACK;
               end else begin
                  st_q   <= F_IDLE;
                  done_q <= 1'b1;
               end
            end
            F_DRAIN: begin
               if (beat_adv && beat_last) begin
                  if (dirty_q) begin
                     st_q <= F_WBACK;
                  end else begin
                     st_q   <= F_IDLE;
                     done_q <= 1'b1;
                  end
               end
            end
            F_WBACK: begin
               if (beat_adv && beat_last) begin
                  st_q   <= F_IDLE;
                  done_q <= 1'b1;
               end
            end
            default: st_q <= F_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/lflush_ctrl_chk.sv
module lflush_ctrl_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              done,
   input logic              tag_wr_en,
   input logic [2:0]        tag_wr_state,
   input logic              mem_wvalid,
   input logic              mem_wready,
   input logic [ADDR_W-1:0] mem_waddr,
   input logic              wcb_clear
);

   a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> !req_ready);

   a_r9_ready_at_done: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> req_ready && !mem_wvalid);

   a_r10_inv_only: assert property (@(posedge clk) disable iff (!rst_n)
      tag_wr_en |-> tag_wr_state == 3'd0);

   a_r8_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wvalid && !mem_wready |=> mem_wvalid && $stable(mem_waddr));

   a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r5_clear_on_beat: assert property (@(posedge clk) disable iff (!rst_n)
      wcb_clear |-> mem_wvalid && mem_wready);

   a_r1_inv_after_beat: assert property (@(posedge clk) disable iff (!rst_n)
      tag_wr_en && mem_wvalid |-> mem_wready);

endmodule

bind lflush_ctrl lflush_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .req_ready    (req_ready),
   .done         (done),
   .tag_wr_en    (tag_wr_en),
   .tag_wr_state (tag_wr_state),
   .mem_wvalid   (mem_wvalid),
   .mem_wready   (mem_wready),
   .mem_waddr    (mem_waddr),
   .wcb_clear    (wcb_clear)
);

// File: tb/lflush_ctrl_bench.sv
module lflush_ctrl_bench;

   localparam int ADDR_W = 32, LADDR_W = 26, SET_W = 4, TAG_W = 22;
   localparam int WAYS = 4, LINE_W = 512, DATA_W = 128;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic                  req_valid = 1'b0;
   logic [LADDR_W-1:0]    req_line = '0;
   logic                  req_ready, done;
   logic [SET_W-1:0]      tag_set;
   logic [WAYS*TAG_W-1:0] tag_rd_tags;
   logic [WAYS*3-1:0]     tag_rd_states;
   logic                  tag_wr_en;
   logic [1:0]            tag_wr_way, dat_way;
   logic [2:0]            tag_wr_state;
   logic [LINE_W-1:0]     dat_line;
   logic                  wcb_valid = 1'b0;
   logic [LADDR_W-1:0]    wcb_line = '0;
   logic [LINE_W-1:0]     wcb_data;
   logic                  wcb_clear;
   logic                  mem_wvalid;
   logic                  mem_wready = 1'b1;
   logic [ADDR_W-1:0]     mem_waddr;
   logic [DATA_W-1:0]     mem_wdata;

   lflush_ctrl u_lflush_ctrl (.*);

   // Cache model
   logic [TAG_W-1:0] tagm [16][4];
   logic [2:0]       stm  [16][4];

   function automatic logic [LINE_W-1:0] line_pat(input logic [3:0] s, input logic [1:0] w);
      logic [LINE_W-1:0] r;
      for (int i = 0; i < 16; i++) r[i*32 +: 32] = {4'h0, s, 6'h0, w, 8'(i), 8'hC3};
      return r;
   endfunction

   function automatic logic [LINE_W-1:0] wcb_pat();
      logic [LINE_W-1:0] r;
      for (int i = 0; i < 16; i++) r[i*32 +: 32] = {8'hEE, 8'(i), 16'h5A5A};
      return r;
   endfunction

   always_comb begin
      for (int w = 0; w < WAYS; w++) begin
         tag_rd_tags[w*TAG_W +: TAG_W] = tagm[tag_set][w];
         tag_rd_states[w*3 +: 3]       = stm[tag_set][w];
      end
      dat_line = line_pat(tag_set, dat_way);
   end
   assign wcb_data = wcb_pat();

   // Memory / event log
   int ecnt = 0, last_acc = 0, log_n = 0, clr_n = 0, twr_n = 0;
   logic [ADDR_W-1:0] log_addr [16];
   logic [DATA_W-1:0] log_data [16];
   logic stall = 1'b0;

   always @(posedge clk) begin
      ecnt <= ecnt + 1;
      if (mem_wvalid && mem_wready) begin
         log_addr[log_n[3:0]] <= mem_waddr;
         log_data[log_n[3:0]] <= mem_wdata;
         log_n    <= log_n + 1;
         last_acc <= ecnt + 1;
      end
      if (tag_wr_en) begin
         stm[tag_set][tag_wr_way] <= tag_wr_state;
         twr_n <= twr_n + 1;
      end
      if (wcb_clear) begin
         clr_n     <= clr_n + 1;
         wcb_valid <= 1'b0;
      end
   end

   always @(negedge clk) mem_wready <= stall ? !mem_wready : 1'b1;

   int nchk = 0, nerr = 0;

   task automatic chk(input string rq, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   task automatic clear_cache();
      for (int s = 0; s < 16; s++)
         for (int w = 0; w < WAYS; w++) begin
            stm[s][w]  = 3'd0;
            tagm[s][w] = TAG_W'(s * 7 + w);
         end
   endtask

   function automatic logic [LADDR_W-1:0] mk_line(input logic [TAG_W-1:0] t, input logic [3:0] s);
      return {t, s};
   endfunction

   // Issue one flush; returns edge count at acceptance and at done
   task automatic run_flush(input logic [LADDR_W-1:0] ln, output int acc_e, output int done_e);
      @(negedge clk);
      log_n = 0; clr_n = 0; twr_n = 0;
      req_valid = 1'b1; req_line = ln;
      @(negedge clk);
      req_valid = 1'b0;
      acc_e = ecnt;
      for (int i = 0; i < 200 && !done; i++) @(negedge clk);
      done_e = ecnt;
      @(negedge clk);
      chk("R8 done single pulse", DATA_W'(done), '0);
   endtask

   task automatic check_beats(input string rq, input int first, input logic [LADDR_W-1:0] ln,
                              input logic [LINE_W-1:0] exp_line);
      for (int b = 0; b < 4; b++) begin
         chk({rq, " beat addr"}, DATA_W'(log_addr[first+b]), DATA_W'({ln, 6'b0} + 32'(b * 16)));
         chk({rq, " beat data"}, log_data[first+b], exp_line[b*DATA_W +: DATA_W]);
      end
   endtask

   task automatic t_reset();
      chk("R9 ready after reset", DATA_W'(req_ready), 1);
      chk("R8 done low after reset", DATA_W'(done), 0);
      chk("R1 no write after reset", DATA_W'(mem_wvalid), 0);
      chk("R5 no clear after reset", DATA_W'(wcb_clear), 0);
   endtask

   task automatic t_dirty(input string rq, input logic [2:0] st, input logic use_stall);
      int a, d;
      logic [LADDR_W-1:0] ln;
      clear_cache();
      ln = mk_line(22'h1ABC, 4'd3);
      tagm[3][1] = 22'h1ABC; stm[3][1] = st;
      stall = use_stall;
      run_flush(ln, a, d);
      stall = 1'b0;
      chk({rq, " beat count"}, DATA_W'(log_n), 4);
      check_beats(rq, 0, ln, line_pat(4'd3, 2'd1));
      chk({rq, " state invalid"}, DATA_W'(stm[3][1]), 0);
      chk({rq, " one tag write"}, DATA_W'(twr_n), 1);
      chk("R8 done after last beat", DATA_W'(d), DATA_W'(last_acc));
   endtask

   task automatic t_clean(input logic [2:0] st);
      int a, d;
      clear_cache();
      tagm[9][2] = 22'h0F0F; stm[9][2] = st;
      run_flush(mk_line(22'h0F0F, 4'd9), a, d);
      chk("R3 clean no write", DATA_W'(log_n), 0);
      chk("R3 clean invalid", DATA_W'(stm[9][2]), 0);
      chk("R3 done two cycles", DATA_W'(d - a), 1);
   endtask

   task automatic t_miss();
      int a, d;
      clear_cache();
      tagm[5][0] = 22'h2222;                    // tag matches, state Invalid (R10)
      tagm[5][2] = 22'h3333; stm[5][2] = 3'd4;  // other tag, Modified
      run_flush(mk_line(22'h2222, 4'd5), a, d);
      chk("R4 miss no write", DATA_W'(log_n), 0);
      chk("R10 invalid way no hit", DATA_W'(twr_n), 0);
      chk("R4 other way kept", DATA_W'(stm[5][2]), 4);
      chk("R4 done two cycles", DATA_W'(d - a), 1);
   endtask

   task automatic t_wcb_miss();
      int a, d;
      logic [LADDR_W-1:0] ln;
      clear_cache();
      ln = mk_line(22'h0777, 4'd12);
      wcb_line = ln; wcb_valid = 1'b1;
      run_flush(ln, a, d);
      chk("R5 drain beat count", DATA_W'(log_n), 4);
      check_beats("R5", 0, ln, wcb_pat());
      chk("R5 clear once", DATA_W'(clr_n), 1);
      chk("R5 done after drain", DATA_W'(d), DATA_W'(last_acc));
   endtask

   task automatic t_both();
      int a, d;
      logic [LADDR_W-1:0] ln;
      clear_cache();
      ln = mk_line(22'h1111, 4'd7);
      tagm[7][3] = 22'h1111; stm[7][3] = 3'd4;
      wcb_line = ln; wcb_valid = 1'b1;
      stall = 1'b1;
      run_flush(ln, a, d);
      stall = 1'b0;
      chk("R6 total beats", DATA_W'(log_n), 8);
      check_beats("R6 drain first", 0, ln, wcb_pat());
      check_beats("R6 line last", 4, ln, line_pat(4'd7, 2'd3));
      chk("R6 invalid", DATA_W'(stm[7][3]), 0);
      chk("R6 clear once", DATA_W'(clr_n), 1);
   endtask

   task automatic t_wcb_other();
      int a, d;
      clear_cache();
      tagm[2][0] = 22'h0444; stm[2][0] = 3'd1;
      wcb_line = mk_line(22'h0445, 4'd2); wcb_valid = 1'b1;
      run_flush(mk_line(22'h0444, 4'd2), a, d);
      chk("R7 no write", DATA_W'(log_n), 0);
      chk("R7 no clear", DATA_W'(clr_n), 0);
      chk("R7 buffer kept", DATA_W'(wcb_valid), 1);
      chk("R7 line invalid", DATA_W'(stm[2][0]), 0);
      wcb_valid = 1'b0;
   endtask

   task automatic t_busy();
      logic [LADDR_W-1:0] la, lb;
      clear_cache();
      la = mk_line(22'h0AAA, 4'd1); lb = mk_line(22'h0BBB, 4'd4);
      tagm[1][0] = 22'h0AAA; stm[1][0] = 3'd4;
      tagm[4][1] = 22'h0BBB; stm[4][1] = 3'd4;
      stall = 1'b1;
      @(negedge clk);
      log_n = 0; twr_n = 0;
      req_valid = 1'b1; req_line = la;
      @(negedge clk);
      req_line = lb;                 // held request while busy
      chk("R9 ready low while busy", DATA_W'(req_ready), 0);
      for (int i = 0; i < 200 && !done; i++) @(negedge clk);
      req_valid = 1'b0;
      stall = 1'b0;
      repeat (3) @(negedge clk);
      chk("R9 only first serviced", DATA_W'(log_n), 4);
      chk("R9 held line untouched", DATA_W'(stm[4][1]), 4);
      chk("R9 first line invalid", DATA_W'(stm[1][0]), 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

   initial begin
      clear_cache();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_dirty("R1", 3'd4, 1'b0);
      t_dirty("R2", 3'd3, 1'b1);
      t_clean(3'd2);
      t_clean(3'd1);
      t_miss();
      t_wcb_miss();
      t_both();
      t_wcb_other();
      t_busy();
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

endmodule